// File: doc/BRIEF.md
# Static Memory Strobe Timing Engine

This block runs single accesses to one asynchronous static memory device. A requester presents an address, write data, byte enables and a direction while the engine is idle. The engine then holds the address on the memory pins for a programmed number of clock cycles. Inside that fixed frame it shapes three active-low strobes: a chip select, a read strobe and a write strobe. Each strobe has its own setup count, measured from the first cycle the address is valid, and its own pulse count. Reads and writes use separate setup and pulse values for the chip select, and each direction has its own frame length.

Two selectable points govern data movement. For reads, the data is captured either as the chip select rises or as the read strobe rises. For writes, the data bus output enable turns on either when the chip select falls or when the write strobe falls. It then stays on until the frame ends. The byte lanes can be signalled in two ways. In the first, one shared write strobe is qualified by per-lane select lines. In the second, each lane gets its own write strobe. The lane count is set by a bus-width parameter of 1, 2 or 4 bytes.

Top module: `smem_strobe_engine`

## Requirements
- R1: After reset `mem_cs_n`, `mem_re_n`, every bit of `mem_we_n` and every bit of `mem_bs_n` are 1, `mem_doe` and `rsp_done` are 0, `rsp_rdata` is 0 and `req_ready` is 1.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `mem_addr` carries the request address from the next cycle, which is frame cycle 0, and does not change until the frame ends.
- R3: In frame cycle k, a strobe with setup S and pulse P is asserted exactly when P > 0, S <= k, k < S+P and k < L-1. L is the frame length. A setup of 0 therefore asserts the strobe in frame cycle 0, together with the address.
- R4: In the last frame cycle (k = L-1) all strobes are deasserted, however long the programmed pulses are.
- R5: A frame lasts L cycles, where L is the programmed cycle count, or 1 when that count is 0. `rsp_done` is 1 in cycle L-1 only. `req_ready` returns to 1 in the cycle after.
- R6: With `cfg_rd_on_re`=0 the read data is the `mem_din` value of the last cycle in which the chip select was low. With `cfg_rd_on_re`=1 it is the value of the last cycle in which the read strobe was low. It is presented on `rsp_rdata` in the `rsp_done` cycle. If the chosen strobe never asserts, `rsp_rdata` keeps its previous value.
- R7: On a write, `mem_doe` is 1 from frame cycle S through cycle L-1. S is the write chip-select setup when `cfg_wr_on_we`=0, or the write-strobe setup when it is 1. `mem_dout` carries the request write data.
- R8: A read never asserts any write strobe and never drives `mem_doe`. A write never asserts `mem_re_n`.
- R9: With `cfg_byte_write`=0, every bit of `mem_we_n` follows the one write window. `mem_bs_n[i]` is low exactly when the chip select is low and `req_be[i]` of the request was 1.
- R10: With `cfg_byte_write`=1, `mem_bs_n` stays all ones. `mem_we_n[i]` is low exactly when the write window is open and `req_be[i]` of the request was 1.
- R11: A request raised while a frame is running is ignored. The address and strobes are not disturbed, and no new frame follows once the running one completes if the request has been withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 8*BUS_BYTES | Write data |
| req_be | input | BUS_BYTES | Byte enables, one per lane |
| req_ready | output | 1 | Engine idle, request can be taken |
| rsp_done | output | 1 | One-cycle pulse in the last frame cycle |
| rsp_rdata | output | 8*BUS_BYTES | Captured read data |
| cfg_rd_cs_setup | input | CNT_W | Read chip-select setup |
| cfg_rd_cs_pulse | input | CNT_W | Read chip-select pulse |
| cfg_rd_re_setup | input | CNT_W | Read strobe setup |
| cfg_rd_re_pulse | input | CNT_W | Read strobe pulse |
| cfg_wr_cs_setup | input | CNT_W | Write chip-select setup |
| cfg_wr_cs_pulse | input | CNT_W | Write chip-select pulse |
| cfg_wr_we_setup | input | CNT_W | Write strobe setup |
| cfg_wr_we_pulse | input | CNT_W | Write strobe pulse |
| cfg_rd_cycle | input | CNT_W | Read frame length |
| cfg_wr_cycle | input | CNT_W | Write frame length |
| cfg_rd_on_re | input | 1 | Read capture point select |
| cfg_wr_on_we | input | 1 | Write drive start select |
| cfg_byte_write | input | 1 | Byte lane mode select |
| mem_addr | output | ADDR_W | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | BUS_BYTES | Write strobes, active low |
| mem_bs_n | output | BUS_BYTES | Byte selects, active low |
| mem_dout | output | 8*BUS_BYTES | Data toward memory |
| mem_doe | output | 1 | Data output enable |
| mem_din | input | 8*BUS_BYTES | Data from memory |

## Verification
The bench builds the engine with two byte lanes, a 5-bit cycle counter and a 12-bit address. Two lanes are the least that lets a single-lane enable pattern tell byte-select signalling apart from per-lane write strobes. The 5-bit counter leaves room for pulse counts far beyond the frame length, so truncation at the final cycle is reachable. A frame length of zero collapses to a single cycle with no strobe at all. Setups of zero, zero-length pulses and both capture and drive points are all reachable at these sizes.

// File: rtl/smem_pkg.sv
package smem_pkg;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACTIVE = 1'b1
    } seq_state_t;

    localparam int NUM_WIN = 3;
    localparam int WIN_CS  = 0;
    localparam int WIN_RE  = 1;
    localparam int WIN_WE  = 2;

endpackage

// File: rtl/smem_strobe_win.sv
module smem_strobe_win #(
    parameter int CNT_W = 6
) (
    input  logic             busy,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] last_val,
    input  logic [CNT_W-1:0] setup,
    input  logic [CNT_W-1:0] pulse,
    output logic             win_on,
    output logic             win_end
);
    logic [CNT_W:0] cnt_x;
    logic [CNT_W:0] nxt_x;
    logic [CNT_W:0] lo_x;
    logic [CNT_W:0] hi_x;
    logic [CNT_W:0] last_x;
    logic           open_now;
    logic           open_nxt;

    always_comb begin
        cnt_x    = {1'b0, cnt};
        nxt_x    = cnt_x + 1'b1;
        lo_x     = {1'b0, setup};
        hi_x     = lo_x + {1'b0, pulse};
        last_x   = {1'b0, last_val};
        open_now = (pulse != '0) && (cnt_x >= lo_x) && (cnt_x < hi_x) && (cnt_x < last_x);
        open_nxt = (pulse != '0) && (nxt_x >= lo_x) && (nxt_x < hi_x) && (nxt_x < last_x);
        win_on   = busy && open_now;
        win_end  = win_on && !open_nxt;
    end

endmodule

// File: rtl/smem_lane_drive.sv
module smem_lane_drive #(
    parameter int LANES = 2
) (
    input  logic             cs_on,
    input  logic             we_on,
    input  logic             byte_write,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] we_n,
    output logic [LANES-1:0] bs_n
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            if (byte_write) begin
                we_n[i] = !(we_on && be[i]);
                bs_n[i] = 1'b1;
            end else begin
                we_n[i] = !we_on;
                bs_n[i] = !(cs_on && be[i]);
            end
        end
    end

endmodule

// File: rtl/smem_seq.sv
module smem_seq
    import smem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LANES  = 2,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic [CNT_W-1:0]  cfg_rd_cycle,
    input  logic [CNT_W-1:0]  cfg_wr_cycle,
    output logic              req_ready,
    output logic              busy,
    output logic              done,
    output logic              op_write,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  last_val,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [LANES-1:0]  be_q
);
    seq_state_t       state_q;
    seq_state_t       state_d;
    logic             accept;
    logic [CNT_W-1:0] cyc_sel;

    // next-state decode
    always_comb begin
        cyc_sel  = op_write ? cfg_wr_cycle : cfg_rd_cycle;
        last_val = (cyc_sel == '0) ? '0 : cyc_sel - 1'b1;
        accept   = 1'b0;
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    state_d = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (cnt == last_val) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // frame counter and request hold
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            op_write <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            be_q     <= '0;
        end else if (accept) begin
            cnt      <= '0;
            op_write <= req_write;
            addr_q   <= req_addr;
            wdata_q  <= req_wdata;
            be_q     <= req_be;
        end else if (state_q == ST_ACTIVE && state_d == ST_ACTIVE) begin
            cnt <= cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        busy      = (state_q == ST_ACTIVE);
        done      = busy && (cnt == last_val);
    end

endmodule

// File: rtl/smem_strobe_engine.sv
module smem_strobe_engine
    import smem_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BUS_BYTES = 2,
    parameter int CNT_W     = 6,
    localparam int LANES    = BUS_BYTES,
    localparam int DATA_W   = 8 * BUS_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [CNT_W-1:0]  cfg_rd_cs_setup,
    input  logic [CNT_W-1:0]  cfg_rd_cs_pulse,
    input  logic [CNT_W-1:0]  cfg_rd_re_setup,
    input  logic [CNT_W-1:0]  cfg_rd_re_pulse,
    input  logic [CNT_W-1:0]  cfg_wr_cs_setup,
    input  logic [CNT_W-1:0]  cfg_wr_cs_pulse,
    input  logic [CNT_W-1:0]  cfg_wr_we_setup,
    input  logic [CNT_W-1:0]  cfg_wr_we_pulse,
    input  logic [CNT_W-1:0]  cfg_rd_cycle,
    input  logic [CNT_W-1:0]  cfg_wr_cycle,
    input  logic              cfg_rd_on_re,
    input  logic              cfg_wr_on_we,
    input  logic              cfg_byte_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_re_n,
    output logic [LANES-1:0]  mem_we_n,
    output logic [LANES-1:0]  mem_bs_n,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_doe,
    input  logic [DATA_W-1:0] mem_din
);
    if (BUS_BYTES != 1 && BUS_BYTES != 2 && BUS_BYTES != 4) begin : g_bad_width
        $error("BUS_BYTES must be 1, 2 or 4");
    end

    logic               busy;
    logic               op_write;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   last_val;
    logic [DATA_W-1:0]  wdata_q;
    logic [LANES-1:0]   be_q;
    logic [CNT_W-1:0]   win_setup [NUM_WIN];
    logic [CNT_W-1:0]   win_pulse [NUM_WIN];
    logic [NUM_WIN-1:0] win_on;
    logic [NUM_WIN-1:0] win_end;
    logic               cap_fire;
    logic [CNT_W-1:0]   drive_from;

    smem_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_be       (req_be),
        .cfg_rd_cycle (cfg_rd_cycle),
        .cfg_wr_cycle (cfg_wr_cycle),
        .req_ready    (req_ready),
        .busy         (busy),
        .done         (rsp_done),
        .op_write     (op_write),
        .cnt          (cnt),
        .last_val     (last_val),
        .addr_q       (mem_addr),
        .wdata_q      (wdata_q),
        .be_q         (be_q)
    );

    // per-window timing selected by direction
    always_comb begin
        win_setup[WIN_CS] = op_write ? cfg_wr_cs_setup : cfg_rd_cs_setup;
        win_pulse[WIN_CS] = op_write ? cfg_wr_cs_pulse : cfg_rd_cs_pulse;
        win_setup[WIN_RE] = cfg_rd_re_setup;
        win_pulse[WIN_RE] = op_write ? '0 : cfg_rd_re_pulse;
        win_setup[WIN_WE] = cfg_wr_we_setup;
        win_pulse[WIN_WE] = op_write ? cfg_wr_we_pulse : '0;
    end

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        smem_strobe_win #(
            .CNT_W (CNT_W)
        ) u_win (
            .busy     (busy),
            .cnt      (cnt),
            .last_val (last_val),
            .setup    (win_setup[w]),
            .pulse    (win_pulse[w]),
            .win_on   (win_on[w]),
            .win_end  (win_end[w])
        );
    end

    smem_lane_drive #(
        .LANES (LANES)
    ) u_lane (
        .cs_on      (win_on[WIN_CS]),
        .we_on      (win_on[WIN_WE]),
        .byte_write (cfg_byte_write),
        .be         (be_q),
        .we_n       (mem_we_n),
        .bs_n       (mem_bs_n)
    );

    always_comb begin
        mem_cs_n   = !win_on[WIN_CS];
        mem_re_n   = !win_on[WIN_RE];
        cap_fire   = !op_write && (cfg_rd_on_re ? win_end[WIN_RE] : win_end[WIN_CS]);
        drive_from = cfg_wr_on_we ? cfg_wr_we_setup : cfg_wr_cs_setup;
        mem_doe    = busy && op_write && (cnt >= drive_from);
        mem_dout   = wdata_q;
    end

    // read capture on the deasserting edge of the chosen strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (cap_fire) begin
            rsp_rdata <= mem_din;
        end
    end

endmodule

// File: rtl/smem_strobe_chk.sv
module smem_strobe_chk #(
    parameter int ADDR_W = 16,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_re_n,
    input logic [LANES-1:0]  mem_we_n,
    input logic [LANES-1:0]  mem_bs_n,
    input logic              mem_doe
);
    // R2: address held for the whole frame
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !rsp_done) |=> $stable(mem_addr));

    // R4: no strobe open in the final cycle
    a_r4_last_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (mem_cs_n && mem_re_n && (&mem_we_n)));

    // R5: done is a single pulse followed by idle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> (!rsp_done && req_ready));

    // R5: idle frames keep every line quiet
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_re_n && (&mem_we_n) && (&mem_bs_n) && !mem_doe));

    // R8: read strobe and write strobes never overlap
    a_r8_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_re_n |-> ((&mem_we_n) && !mem_doe));

    // R9: byte selects only inside chip select
    a_r9_bs_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&mem_bs_n)) |-> !mem_cs_n);

    // R11: a running frame is not cut short
    a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !rsp_done) |=> !req_ready);

endmodule

bind smem_strobe_engine smem_strobe_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_re_n  (mem_re_n),
    .mem_we_n  (mem_we_n),
    .mem_bs_n  (mem_bs_n),
    .mem_doe   (mem_doe)
);

// File: tb/tb_smem_strobe_engine.sv
module tb_smem_strobe_engine;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int BYTES      = 2;
    localparam int CNT_W      = 5;
    localparam int DW         = 8 * BYTES;

    typedef struct packed {
        logic       wr;
        logic       rm;
        logic       wm;
        logic       bw;
        logic [1:0] be;
        logic [4:0] cs_s;
        logic [4:0] cs_p;
        logic [4:0] st_s;
        logic [4:0] st_p;
        logic [4:0] cyc;
        logic [4:0] len;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 5'd1, 5'd4,  5'd2, 5'd2, 5'd8,  5'd8},
        '{1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 5'd1, 5'd4,  5'd2, 5'd2, 5'd8,  5'd8},
        '{1'b0, 1'b1, 1'b0, 1'b0, 2'b11, 5'd0, 5'd3,  5'd0, 5'd2, 5'd5,  5'd5},
        '{1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 5'd2, 5'd20, 5'd3, 5'd20, 5'd6, 5'd6},
        '{1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 5'd1, 5'd5,  5'd3, 5'd2, 5'd8,  5'd8},
        '{1'b1, 1'b0, 1'b1, 1'b1, 2'b10, 5'd1, 5'd5,  5'd3, 5'd2, 5'd8,  5'd8},
        '{1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 5'd0, 5'd4,  5'd2, 5'd0, 5'd6,  5'd6},
        '{1'b0, 1'b0, 1'b0, 1'b0, 2'b11, 5'd0, 5'd3,  5'd0, 5'd3, 5'd0,  5'd1},
        '{1'b1, 1'b0, 1'b1, 1'b0, 2'b11, 5'd0, 5'd7,  5'd2, 5'd3, 5'd12, 5'd12},
        '{1'b0, 1'b1, 1'b0, 1'b1, 2'b01, 5'd1, 5'd3,  5'd1, 5'd3, 5'd6,  5'd6}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DW-1:0]     req_wdata = '0;
    logic [BYTES-1:0]  req_be = '0;
    logic              req_ready;
    logic              rsp_done;
    logic [DW-1:0]     rsp_rdata;
    logic [CNT_W-1:0]  cfg_rd_cs_setup = '0, cfg_rd_cs_pulse = '0;
    logic [CNT_W-1:0]  cfg_rd_re_setup = '0, cfg_rd_re_pulse = '0;
    logic [CNT_W-1:0]  cfg_wr_cs_setup = '0, cfg_wr_cs_pulse = '0;
    logic [CNT_W-1:0]  cfg_wr_we_setup = '0, cfg_wr_we_pulse = '0;
    logic [CNT_W-1:0]  cfg_rd_cycle = '0, cfg_wr_cycle = '0;
    logic              cfg_rd_on_re = 1'b0, cfg_wr_on_we = 1'b0, cfg_byte_write = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_cs_n, mem_re_n, mem_doe;
    logic [BYTES-1:0]  mem_we_n, mem_bs_n;
    logic [DW-1:0]     mem_dout;
    logic [DW-1:0]     mem_din = '0;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;
    logic [DW-1:0] rd_model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    smem_strobe_engine #(
        .ADDR_W    (ADDR_W),
        .BUS_BYTES (BYTES),
        .CNT_W     (CNT_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .cfg_rd_cs_setup(cfg_rd_cs_setup), .cfg_rd_cs_pulse(cfg_rd_cs_pulse),
        .cfg_rd_re_setup(cfg_rd_re_setup), .cfg_rd_re_pulse(cfg_rd_re_pulse),
        .cfg_wr_cs_setup(cfg_wr_cs_setup), .cfg_wr_cs_pulse(cfg_wr_cs_pulse),
        .cfg_wr_we_setup(cfg_wr_we_setup), .cfg_wr_we_pulse(cfg_wr_we_pulse),
        .cfg_rd_cycle(cfg_rd_cycle), .cfg_wr_cycle(cfg_wr_cycle),
        .cfg_rd_on_re(cfg_rd_on_re), .cfg_wr_on_we(cfg_wr_on_we),
        .cfg_byte_write(cfg_byte_write),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_re_n(mem_re_n),
        .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n), .mem_dout(mem_dout),
        .mem_doe(mem_doe), .mem_din(mem_din)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit win(int s, int p, int k, int c);
        return (p > 0) && (k >= s) && (k < s + p) && (k < c - 1);
    endfunction

    function automatic logic [DW-1:0] din_val(int v, int k);
        return 16'h5A00 | DW'(v << 4) | DW'(k);
    endfunction

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    task automatic load_cfg(input vec_t v);
        cfg_rd_on_re   = v.rm;
        cfg_wr_on_we   = v.wm;
        cfg_byte_write = v.bw;
        if (v.wr) begin
            cfg_wr_cs_setup = v.cs_s; cfg_wr_cs_pulse = v.cs_p;
            cfg_wr_we_setup = v.st_s; cfg_wr_we_pulse = v.st_p;
            cfg_wr_cycle    = v.cyc;
            cfg_rd_cs_setup = 5'd9;   cfg_rd_cs_pulse = 5'd1;
            cfg_rd_re_setup = 5'd9;   cfg_rd_re_pulse = 5'd1;
            cfg_rd_cycle    = 5'd2;
        end else begin
            cfg_rd_cs_setup = v.cs_s; cfg_rd_cs_pulse = v.cs_p;
            cfg_rd_re_setup = v.st_s; cfg_rd_re_pulse = v.st_p;
            cfg_rd_cycle    = v.cyc;
            cfg_wr_cs_setup = 5'd9;   cfg_wr_cs_pulse = 5'd1;
            cfg_wr_we_setup = 5'd9;   cfg_wr_we_pulse = 5'd1;
            cfg_wr_cycle    = 5'd2;
        end
    endtask

    // called at a negedge with the engine idle
    task automatic run_vec(input int vi);
        vec_t v;
        int   c;
        int   ds;
        logic [ADDR_W-1:0] a;
        logic [DW-1:0]     wd;
        v  = VECS[vi];
        c  = (v.cyc == 0) ? 1 : int'(v.cyc);
        ds = v.wm ? int'(v.st_s) : int'(v.cs_s);
        a  = ADDR_W'(12'h300 + vi * 37);
        wd = 16'hC000 | DW'(vi * 16'h0111);
        load_cfg(v);
        chk("R2 ready before request", 32'(req_ready), 32'd1);
        req_write = v.wr; req_addr = a; req_wdata = wd; req_be = v.be; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = ~a;
        for (int k = 0; k < c; k++) begin
            bit cs_e, st_e, we_on;
            logic [1:0] we_e, bs_e;
            cs_e  = win(v.cs_s, v.cs_p, k, c);
            st_e  = win(v.st_s, v.st_p, k, c);
            we_on = v.wr && st_e;
            we_e  = v.bw ? ~({2{we_on}} & v.be) : {2{~we_on}};
            bs_e  = v.bw ? 2'b11 : ~({2{cs_e}} & v.be);
            chk("R2 address held", 32'(mem_addr), 32'(a));
            chk("R3 R4 chip select", 32'(mem_cs_n), 32'(!cs_e));
            chk("R3 R8 read strobe", 32'(mem_re_n), 32'(!(!v.wr && st_e)));
            chk(v.bw ? "R10 write strobes" : "R9 write strobes", 32'(mem_we_n), 32'(we_e));
            chk(v.bw ? "R10 byte selects" : "R9 byte selects", 32'(mem_bs_n), 32'(bs_e));
            chk("R7 R8 output enable", 32'(mem_doe), 32'(v.wr && (k >= ds)));
            if (v.wr) chk("R7 write data", 32'(mem_dout), 32'(wd));
            chk("R5 done timing", 32'(rsp_done), 32'(k == int'(v.len) - 1));
            if (!v.wr) begin
                bit on_now, on_nxt;
                on_now = v.rm ? st_e : cs_e;
                on_nxt = v.rm ? win(v.st_s, v.st_p, k + 1, c) : win(v.cs_s, v.cs_p, k + 1, c);
                if (k == c - 1) chk("R6 read data with done", 32'(rsp_rdata), 32'(rd_model));
                if (on_now && !on_nxt) rd_model = din_val(vi, k);
            end
            mem_din = din_val(vi, k);
            @(negedge clk);
        end
        chk("R5 ready after frame", 32'(req_ready), 32'd1);
        chk("R5 done cleared", 32'(rsp_done), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cs_n", 32'(mem_cs_n), 32'd1);
        chk("R1 re_n", 32'(mem_re_n), 32'd1);
        chk("R1 we_n", 32'(mem_we_n), 32'h3);
        chk("R1 bs_n", 32'(mem_bs_n), 32'h3);
        chk("R1 doe", 32'(mem_doe), 32'd0);
        chk("R1 done", 32'(rsp_done), 32'd0);
        chk("R1 rdata", 32'(rsp_rdata), 32'd0);
        chk("R1 ready", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int vi = 0; vi < NV; vi++) begin
            run_vec(vi);
        end

        // R11: request during a running frame is ignored
        load_cfg(VECS[0]);
        req_write = 1'b0; req_addr = 12'h0AB; req_be = 2'b11; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 8; k++) begin
            if (k == 2) begin
                req_write = 1'b1; req_addr = 12'h777; req_valid = 1'b1;
            end
            if (k == 4) req_valid = 1'b0;
            chk("R11 address kept", 32'(mem_addr), 32'h0AB);
            chk("R11 no write strobe", 32'(mem_we_n), 32'h3);
            chk("R11 frame length", 32'(rsp_done), 32'(k == 7));
            @(negedge clk);
        end
        for (int k = 0; k < 3; k++) begin
            chk("R11 stays idle", 32'(req_ready), 32'd1);
            chk("R11 no new frame", 32'(mem_cs_n), 32'd1);
            chk("R11 address unchanged", 32'(mem_addr), 32'h0AB);
            @(negedge clk);
        end

        // R1: reset mid-frame returns everything to idle
        req_addr = 12'h155; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1 reset mid-frame ready", 32'(req_ready), 32'd1);
        chk("R1 reset mid-frame cs_n", 32'(mem_cs_n), 32'd1);
        chk("R1 reset mid-frame rdata", 32'(rsp_rdata), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        report();
    end

endmodule